// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This block sits beside one UART channel and throttles traffic in both directions without software help. On the receive side it compares the fill level of a 64-entry receive FIFO against two programmable thresholds and uses hysteresis between them. From that comparison it drops RTS when the FIFO is close to full and raises it again once the FIFO has drained. When software flow control is selected, the same two crossings produce one-cycle requests asking the transmit path to insert an Xoff or an Xon character.

On the transmit side it produces a single enable that the transmitter samples before it starts a character. The enable falls when the remote end deasserts CTS, if hardware flow control is on. It also falls when a received character matches the programmed Xoff value, if software flow control is on. The enable changes only while the transmitter reports that it is idle, so a character already on the line is always finished. Received Xon and Xoff characters are removed from the stream, and a store strobe tells the FIFO which characters to keep. An optional mode lets any received character restart a transmitter that an Xoff has stopped.

Top module: `uart_flowctl`

## Requirements
- R1: While reset is active and in the first cycle after it, rts_o=1, tx_en_o=1, xon_req_o=0 and xoff_req_o=0.
- R2: With hw_en_i=1 and a valid threshold pair, rts_o goes to 0 one clock after rx_level_i is at or above 4*halt_thr_i. It stays 0 while the level stays above 4*resume_thr_i.
- R3: Once rts_o is 0 under R2, it returns to 1 one clock after rx_level_i is at or below 4*resume_thr_i.
- R4: If resume_thr_i >= halt_thr_i, the thresholds are ignored: rts_o stays 1 and neither request is raised, whatever the level.
- R5: With hw_en_i=1, cts_i=0 (default polarity, 1 means clear to send) causes tx_en_o to fall at the first clock edge where tx_idle_i=1. While tx_idle_i=0, tx_en_o does not change at all.
- R6: With sw_en_i=1, a received character equal to xoff_char_i stops the transmitter. tx_en_o falls at the first idle edge after the character's clock. A later received xon_char_i restarts it the same way. If a character matches both values, it is treated as Xoff.
- R7: With any_resume_i=1 and the transmitter stopped by Xoff, any received character other than xoff_char_i also restarts it.
- R8: With sw_en_i=1, xoff_req_o pulses for exactly one cycle when the level enters the halt region, and xon_req_o pulses for one cycle when it returns to the resume region. Changes of level inside one region give no further pulse. The two requests are never high together.
- R9: rx_store_o equals rx_valid_i, except that it is 0 for a character matching xon_char_i or xoff_char_i while sw_en_i=1. A non-matching character that resumes under R7 is stored.
- R10: With hw_en_i=0, cts_i has no effect on tx_en_o and rts_o stays 1. With sw_en_i=0, no character is recognised, every valid character is stored, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_en_i | input | 1 | Enable RTS/CTS flow control |
| sw_en_i | input | 1 | Enable Xon/Xoff flow control |
| any_resume_i | input | 1 | Any received character resumes after Xoff |
| halt_thr_i | input | 4 | Halt threshold, units of 4 entries |
| resume_thr_i | input | 4 | Resume threshold, units of 4 entries |
| xon_char_i | input | 8 | Programmed Xon character |
| xoff_char_i | input | 8 | Programmed Xoff character |
| rx_level_i | input | 7 | Receive FIFO fill level, 0 to 64 |
| rx_char_i | input | 8 | Received character |
| rx_valid_i | input | 1 | Received character strobe |
| cts_i | input | 1 | Clear-to-send input |
| tx_idle_i | input | 1 | Transmitter is between characters |
| rts_o | output | 1 | Request-to-send output, 1 = ready |
| tx_en_o | output | 1 | Transmitter may start a character |
| xon_req_o | output | 1 | One-cycle request to send Xon |
| xoff_req_o | output | 1 | One-cycle request to send Xoff |
| rx_store_o | output | 1 | Write the received character into the FIFO |

## Verification
The receive level is swept up and down through a valid threshold pair. This shows that RTS and the requests follow hysteresis rather than a single compare. A short wobble around the halt point is added, which separates "once per crossing" from "once per cycle above threshold". The same sweep is repeated with an inverted threshold pair to show that invalid settings are ignored. CTS and Xoff changes are applied while tx_idle_i is low and again while it is high, which shows that the enable changes only at a character boundary. Character bursts are sent with the any-character mode on and off, and with each flow control type disabled, to separate consumption, resumption and independence of the two mechanisms.

// File: rtl/uart_flowctl_pkg.sv
package uart_flowctl_pkg;

   typedef enum logic {
      FILL_LOW  = 1'b0,
      FILL_HIGH = 1'b1
   } fill_state_e;

   typedef struct packed {
      logic xon_hit;
      logic xoff_hit;
   } char_match_t;

endpackage

// File: rtl/fc_level_watch.sv
module fc_level_watch
   import uart_flowctl_pkg::*;
#(
   parameter int LVL_W    = 7,
   parameter int THR_W    = 4,
   parameter int THR_UNIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_en,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [THR_W-1:0] halt_thr,
   input  logic [THR_W-1:0] resume_thr,
   output logic             fill_high,
   output logic             cfg_ok,
   output logic [LVL_W-1:0] halt_lvl,
   output logic             xon_req,
   output logic             xoff_req
);

   logic [LVL_W-1:0] res_lvl;
   fill_state_e      state_q, state_d;

   assign halt_lvl = LVL_W'(halt_thr) * LVL_W'(THR_UNIT);
   assign res_lvl  = LVL_W'(resume_thr) * LVL_W'(THR_UNIT);
   assign cfg_ok   = (resume_thr < halt_thr);

   always_comb begin
      state_d = state_q;
      if (!cfg_ok)                 state_d = FILL_LOW;
      else if (rx_level >= halt_lvl) state_d = FILL_HIGH;
      else if (rx_level <= res_lvl)  state_d = FILL_LOW;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= FILL_LOW;
         xon_req  <= 1'b0;
         xoff_req <= 1'b0;
      end else begin
         state_q  <= state_d;
         xoff_req <= sw_en && cfg_ok && (state_q == FILL_LOW)  && (state_d == FILL_HIGH);
         xon_req  <= sw_en && cfg_ok && (state_q == FILL_HIGH) && (state_d == FILL_LOW);
      end
   end

   assign fill_high = (state_q == FILL_HIGH);

   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(xon_req && xoff_req)); // R8
   AST_XOFF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      xoff_req |=> !xoff_req); // R8
   AST_XON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      xon_req |=> !xon_req); // R8
   AST_BADCFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ok |=> (!fill_high && !xoff_req && !xon_req)); // R4

endmodule

// File: rtl/fc_swrx.sv
module fc_swrx
   import uart_flowctl_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_en,
   input  logic              any_resume,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic [CHAR_W-1:0] xon_char,
   input  logic [CHAR_W-1:0] xoff_char,
   output logic              sw_stop,
   output logic              rx_store
);

   char_match_t hit;

   assign hit.xon_hit  = (rx_char == xon_char);
   assign hit.xoff_hit = (rx_char == xoff_char);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_stop <= 1'b0;
      end else if (!sw_en) begin
         sw_stop <= 1'b0;
      end else if (rx_valid) begin
         if (hit.xoff_hit)                 sw_stop <= 1'b1;
         else if (hit.xon_hit || any_resume) sw_stop <= 1'b0;
      end
   end

   assign rx_store = rx_valid && !(sw_en && (hit.xon_hit || hit.xoff_hit));

   AST_XOFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && sw_en && (rx_char == xoff_char)) |=> sw_stop); // R6
   AST_CONSUME_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && sw_en && ((rx_char == xon_char) || (rx_char == xoff_char))) |-> !rx_store); // R9
   AST_SW_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |=> !sw_stop); // R10

endmodule

// File: rtl/fc_txgate.sv
module fc_txgate (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_en,
   input  logic cts_clear,
   input  logic sw_stop,
   input  logic tx_idle,
   output logic tx_en
);

   logic want_en;

   assign want_en = !(hw_en && !cts_clear) && !sw_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tx_en <= 1'b1;
      else if (tx_idle) tx_en <= want_en;
   end

   AST_TXEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_idle |=> $stable(tx_en)); // R5
   AST_CTS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_idle && hw_en && !cts_clear) |=> !tx_en); // R5

endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl #(
   parameter int FIFO_DEPTH     = 64,
   parameter int THR_W          = 4,
   parameter int THR_UNIT       = 4,
   parameter int CHAR_W         = 8,
   parameter bit CTS_ACTIVE_LOW = 1'b0,
   localparam int LVL_W         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_en_i,
   input  logic              sw_en_i,
   input  logic              any_resume_i,
   input  logic [THR_W-1:0]  halt_thr_i,
   input  logic [THR_W-1:0]  resume_thr_i,
   input  logic [CHAR_W-1:0] xon_char_i,
   input  logic [CHAR_W-1:0] xoff_char_i,
   input  logic [LVL_W-1:0]  rx_level_i,
   input  logic [CHAR_W-1:0] rx_char_i,
   input  logic              rx_valid_i,
   input  logic              cts_i,
   input  logic              tx_idle_i,
   output logic              rts_o,
   output logic              tx_en_o,
   output logic              xon_req_o,
   output logic              xoff_req_o,
   output logic              rx_store_o
);

   localparam int MAX_THR_LVL = ((1 << THR_W) - 1) * THR_UNIT;

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("uart_flowctl: FIFO_DEPTH must be at least 2");
   end
   if (MAX_THR_LVL > FIFO_DEPTH) begin : g_bad_thr
      $error("uart_flowctl: threshold range exceeds FIFO_DEPTH");
   end
   if (THR_UNIT < 1) begin : g_bad_unit
      $error("uart_flowctl: THR_UNIT must be positive");
   end

   logic             cts_clear;
   logic             fill_high;
   logic             cfg_ok;
   logic [LVL_W-1:0] halt_lvl;
   logic             sw_stop;

   if (CTS_ACTIVE_LOW) begin : g_cts_low
      assign cts_clear = !cts_i;
   end else begin : g_cts_high
      assign cts_clear = cts_i;
   end

   fc_level_watch #(
      .LVL_W    (LVL_W),
      .THR_W    (THR_W),
      .THR_UNIT (THR_UNIT)
   ) u_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_en      (sw_en_i),
      .rx_level   (rx_level_i),
      .halt_thr   (halt_thr_i),
      .resume_thr (resume_thr_i),
      .fill_high  (fill_high),
      .cfg_ok     (cfg_ok),
      .halt_lvl   (halt_lvl),
      .xon_req    (xon_req_o),
      .xoff_req   (xoff_req_o)
   );

   fc_swrx #(
      .CHAR_W (CHAR_W)
   ) u_swrx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_en      (sw_en_i),
      .any_resume (any_resume_i),
      .rx_valid   (rx_valid_i),
      .rx_char    (rx_char_i),
      .xon_char   (xon_char_i),
      .xoff_char  (xoff_char_i),
      .sw_stop    (sw_stop),
      .rx_store   (rx_store_o)
   );

   fc_txgate u_txgate (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_en     (hw_en_i),
      .cts_clear (cts_clear),
      .sw_stop   (sw_stop),
      .tx_idle   (tx_idle_i),
      .tx_en     (tx_en_o)
   );

   assign rts_o = !(hw_en_i && fill_high);

   AST_RTS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_en_i && cfg_ok && (rx_level_i >= halt_lvl)) |=> (!rts_o || !hw_en_i)); // R2
   AST_RTS_HW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_en_i |-> rts_o); // R10

endmodule

// File: tb/uart_flowctl_tb_top.sv
module uart_flowctl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_en = 0, sw_en = 0, any_res = 0;
   logic [3:0] halt_thr = 4'd8, res_thr = 4'd2;
   logic [7:0] xon_c = 8'h11, xoff_c = 8'h13;
   logic [6:0] level = 0;
   logic [7:0] rx_char = 0;
   logic       rx_valid = 0, cts = 1, tx_idle = 1;
   logic       rts, tx_en, xon_req, xoff_req, rx_store;

   int n_tests = 0, n_fail = 0, cycles = 0;
   string cur_req = "R1";

   // reference model state
   bit m_over, m_stop, m_txen, m_xon, m_xoff;

   always #10 clk = ~clk;

   uart_flowctl dut_i (
      .clk(clk), .rst_n(rst_n), .hw_en_i(hw_en), .sw_en_i(sw_en), .any_resume_i(any_res),
      .halt_thr_i(halt_thr), .resume_thr_i(res_thr), .xon_char_i(xon_c), .xoff_char_i(xoff_c),
      .rx_level_i(level), .rx_char_i(rx_char), .rx_valid_i(rx_valid), .cts_i(cts),
      .tx_idle_i(tx_idle), .rts_o(rts), .tx_en_o(tx_en), .xon_req_o(xon_req),
      .xoff_req_o(xoff_req), .rx_store_o(rx_store)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_over = 0; m_stop = 0; m_txen = 1; m_xon = 0; m_xoff = 0;
      end else begin
         int  hl, rl;
         bit  ok, nover, nstop;
         hl = int'(halt_thr) * 4;
         rl = int'(res_thr) * 4;
         ok = int'(res_thr) < int'(halt_thr);
         nover = m_over;
         if (!ok) nover = 0;
         else if (int'(level) >= hl) nover = 1;
         else if (int'(level) <= rl) nover = 0;
         m_xoff = sw_en && ok && !m_over && nover;
         m_xon  = sw_en && ok && m_over && !nover;
         nstop = m_stop;
         if (!sw_en) nstop = 0;
         else if (rx_valid) begin
            if (rx_char == xoff_c) nstop = 1;
            else if (rx_char == xon_c || any_res) nstop = 0;
         end
         if (tx_idle) m_txen = !((hw_en && !cts) || m_stop);
         m_over = nover;
         m_stop = nstop;
      end
   end

   task automatic chk(string what, bit got, bit exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got %0b exp %0b at cycle %0d", cur_req, what, got, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      #5;
      cycles++;
      chk("rts_o",      rts,      !(hw_en && m_over));
      chk("tx_en_o",    tx_en,    m_txen);
      chk("xon_req_o",  xon_req,  m_xon);
      chk("xoff_req_o", xoff_req, m_xoff);
      chk("rx_store_o", rx_store,
          rx_valid && !(sw_en && (rx_char == xon_c || rx_char == xoff_c)));
      if (cycles > 100000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(logic [7:0] c);
      @(negedge clk); rx_char = c; rx_valid = 1;
      @(negedge clk); rx_valid = 0;
   endtask

   task automatic sweep(int top);
      for (int i = 0; i <= top; i++) begin @(negedge clk); level = 7'(i); end
      for (int i = top; i >= 0; i--) begin @(negedge clk); level = 7'(i); end
   endtask

   initial begin
      cur_req = "R1";
      wait_cyc(3);
      @(negedge clk); rst_n = 1;
      #5;
      n_tests++;
      if (!(rts === 1 && tx_en === 1 && xon_req === 0 && xoff_req === 0)) begin
         n_fail++;
         $display("FAIL R1 reset state got %0b%0b%0b%0b exp 1100", rts, tx_en, xon_req, xoff_req);
      end
      wait_cyc(2);

      cur_req = "R2"; hw_en = 1;
      sweep(40);
      cur_req = "R3";
      sweep(64);

      cur_req = "R8"; sw_en = 1;
      sweep(36);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); level = 7'd31;
         @(negedge clk); level = 7'd33;
      end
      @(negedge clk); level = 7'd8;
      @(negedge clk); level = 7'd9;
      @(negedge clk); level = 7'd7;
      wait_cyc(2);

      cur_req = "R4"; halt_thr = 4'd3; res_thr = 4'd5;
      sweep(64);
      halt_thr = 4'd4; res_thr = 4'd4;
      sweep(30);
      halt_thr = 4'd8; res_thr = 4'd2;

      cur_req = "R5"; sw_en = 0;
      @(negedge clk); tx_idle = 0; cts = 0;
      wait_cyc(4);
      @(negedge clk); tx_idle = 1;
      wait_cyc(3);
      @(negedge clk); cts = 1; tx_idle = 0;
      wait_cyc(3);
      @(negedge clk); tx_idle = 1;
      wait_cyc(3);

      cur_req = "R6"; sw_en = 1;
      tx_idle = 0;
      send(xoff_c);
      send(8'h41);
      wait_cyc(2);
      @(negedge clk); tx_idle = 1;
      wait_cyc(3);
      send(8'h42);
      wait_cyc(2);
      send(xon_c);
      wait_cyc(3);
      xon_c = 8'h55; xoff_c = 8'h55;
      send(8'h55);
      wait_cyc(3);
      xon_c = 8'h11; xoff_c = 8'h13;
      send(8'h11);
      wait_cyc(3);

      cur_req = "R7"; any_res = 1;
      send(xoff_c);
      wait_cyc(3);
      send(xoff_c);
      send(8'h7E);
      wait_cyc(3);
      send(xoff_c);
      send(xon_c);
      wait_cyc(3);

      cur_req = "R9";
      for (int c = 0; c < 24; c++) send(8'(c));
      any_res = 0;

      cur_req = "R10"; hw_en = 0; sw_en = 0;
      @(negedge clk); cts = 0; level = 7'd60;
      wait_cyc(4);
      send(xoff_c);
      send(xon_c);
      wait_cyc(3);
      @(negedge clk); level = 0; cts = 1;
      wait_cyc(3);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule